// File: doc/BRIEF.md
# DMA Transfer Cycle Sequencer

This block is the central timing engine of a multi-channel DMA controller. While idle it sits in a single one-clock state and looks at three things on every clock: the channel request lines, the CPU register-select and hold acknowledge. If the CPU is selecting the controller's registers, the sequencer enters a programming state and leaves the bus alone. If an enabled channel is requesting instead, it raises a hold request. Once hold acknowledge arrives, it runs transfer cycles through the one-clock states S1 to S4.

A transfer between memory and I/O is done in one bus cycle. A memory command and an I/O command are asserted together, so the data moves directly between the two and the sequencer neither captures nor drives it. A memory-to-memory transfer takes two bus cycles. The first reads a byte into an internal holding register, and the second writes that byte back out from the register. A per-channel stretch option lengthens the command phase. A peripheral can also hold the cycle with its ready input. Channels are served in a fixed order with channel 0 first. Back-to-back requests chain without releasing the bus.

Top module: `dma_xfer_seq`

## Requirements
- R1: After reset, `hrq`, `dack`, all four command strobes, `adr_inc` and `dbus_oe` are low.
- R2: Each channel `i` has a 3-bit field `chan_mode[3*i+2:3*i]`. Bits [1:0] select the transfer: 00 memory to I/O, 01 I/O to memory, 10 memory to memory, 11 channel disabled. Bit 2 selects the stretch option. From idle, an enabled request raises `hrq` one clock later. A request on a disabled channel leaves `hrq` low.
- R3: A CPU register select wins over a pending request. While `cpu_sel` is high, `hrq` stays low. After `cpu_sel` falls, one idle clock passes, and then a pending request raises `hrq`.
- R4: While `hlda` is low, `hrq` stays high and no acknowledge or strobe is issued. The channel acknowledge appears one clock after `hlda` is seen high.
- R5: The lowest-numbered enabled requesting channel is served first. Its `dack` bit stays high, one-hot, from S1 through the final S4 of its transfer.
- R6: Fly-by transfers assert their two strobes together in S2 and S3. Memory to I/O asserts `mem_rd` and `io_wr`. I/O to memory asserts `io_rd` and `mem_wr`. An unstretched fly-by cycle keeps `dack` high for 4 clocks. `dbus_oe` stays low, and the holding register (seen on `dbus_out`) is not reloaded.
- R7: A memory-to-memory transfer runs two bus cycles. The first cycle asserts only `mem_rd`, and `dbus_in` is captured at the end of S3. The second cycle asserts only `mem_wr`, and `dbus_oe` is high from S1 to S4 with the captured byte on `dbus_out`. The unstretched transfer keeps `dack` high for 8 clocks.
- R8: While `ready` is low in S3, the cycle stays in S3 with its strobes held. S4 follows on the clock after `ready` is seen high.
- R9: With the stretch bit set, S2 lasts STRETCH_CLKS extra clocks (default 1), so each bus cycle grows by that many clocks.
- R10: S4 releases all strobes and gives a one-clock `adr_inc` pulse, once per bus cycle.
- R11: If an enabled request is still pending at S4, the next transfer starts at S1 on the following clock and `hrq` stays high. Otherwise `hrq` drops and the sequencer returns to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | DMA clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dreq | input | NCH | Channel service requests |
| chan_mode | input | 3*NCH | Per-channel transfer type and stretch bit |
| cpu_sel | input | 1 | CPU register select |
| hlda | input | 1 | Hold acknowledge from the system |
| ready | input | 1 | Peripheral ready; low inserts waits in S3 |
| dbus_in | input | HOLD_W | Data bus, captured in memory-to-memory reads |
| hrq | output | 1 | Hold request to the system |
| mem_rd | output | 1 | Memory read command |
| mem_wr | output | 1 | Memory write command |
| io_rd | output | 1 | I/O read command |
| io_wr | output | 1 | I/O write command |
| adr_inc | output | 1 | Address-increment pulse in S4 |
| dack | output | NCH | One-hot channel acknowledge |
| dbus_out | output | HOLD_W | Holding register contents |
| dbus_oe | output | 1 | Data bus drive enable, memory-to-memory write cycle |

## Verification
All outputs are decoded from registered state, so each result is due a whole number of clocks after its cause: `hrq` one clock after a request in idle, and `dack` one clock after `hlda` in S0. The strobes come one clock after `dack`, and `adr_inc` comes one clock after `ready` is seen high in S3. The bench changes inputs on the falling edge and samples on the following falling edges. It counts those edges from the moment of stimulus, so each check lands in the exact state where the result is due. Cycle lengths are measured by counting the falling edges on which `dack` is high.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

   typedef enum logic [2:0] {
      ST_SI = 3'd0,
      ST_SP = 3'd1,
      ST_S0 = 3'd2,
      ST_S1 = 3'd3,
      ST_S2 = 3'd4,
      ST_S3 = 3'd5,
      ST_S4 = 3'd6
   } seq_state_t;

   typedef enum logic [1:0] {
      XF_M2IO = 2'd0,
      XF_IO2M = 2'd1,
      XF_M2M  = 2'd2,
      XF_OFF  = 2'd3
   } xfer_t;

   localparam int MODE_W = 3;

endpackage

// File: rtl/dma_seq_arb.sv
module dma_seq_arb
   import dma_seq_pkg::*;
#(
   parameter int NCH  = 4,
   parameter int CH_W = 2
) (
   input  logic [NCH-1:0]        req,
   input  logic [MODE_W*NCH-1:0] mode,
   output logic                  any,
   output logic [CH_W-1:0]       win_ch,
   output logic [MODE_W-1:0]     win_mode
);

   logic [NCH-1:0] live;

   generate
      for (genvar gi = 0; gi < NCH; gi++) begin : g_live
         assign live[gi] = req[gi] && (mode[MODE_W*gi +: 2] != XF_OFF);
      end
   endgenerate

   assign any = |live;

   always_comb begin
      win_ch   = '0;
      win_mode = '0;
      for (int i = NCH - 1; i >= 0; i--) begin
         if (live[i]) begin
            win_ch   = CH_W'(i);
            win_mode = mode[MODE_W*i +: MODE_W];
         end
      end
   end

endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
   import dma_seq_pkg::*;
#(
   parameter int CH_W         = 2,
   parameter int STRETCH_CLKS = 1,
   parameter int SCW          = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_sel,
   input  logic              hlda,
   input  logic              ready,
   input  logic              req_any,
   input  logic [CH_W-1:0]   win_ch,
   input  logic [MODE_W-1:0] win_mode,
   output seq_state_t        state,
   output logic              phase,
   output logic [CH_W-1:0]   cur_ch,
   output xfer_t             cur_type,
   output logic              hrq
);

   logic           cur_str;
   logic [SCW-1:0] scnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_SI;
         phase    <= 1'b0;
         cur_ch   <= '0;
         cur_type <= XF_M2IO;
         cur_str  <= 1'b0;
         scnt     <= '0;
      end else begin
         case (state)
            ST_SI: begin
               if (cpu_sel)      state <= ST_SP;
               else if (req_any) state <= ST_S0;
            end
            ST_SP: begin
               if (!cpu_sel) state <= ST_SI;
            end
            ST_S0: begin
               if (!req_any) begin
                  state <= ST_SI;
               end else if (hlda) begin
                  state    <= ST_S1;
                  phase    <= 1'b0;
                  cur_ch   <= win_ch;
                  cur_type <= xfer_t'(win_mode[1:0]);
                  cur_str  <= win_mode[2];
               end
            end
            ST_S1: begin
               state <= ST_S2;
               scnt  <= cur_str ? SCW'(STRETCH_CLKS) : '0;
            end
            ST_S2: begin
               if (scnt == '0) state <= ST_S3;
               else            scnt  <= scnt - 1'b1;
            end
            ST_S3: begin
               if (ready) state <= ST_S4;
            end
            ST_S4: begin
               if (cur_type == XF_M2M && !phase) begin
                  state <= ST_S1;
                  phase <= 1'b1;
               end else if (req_any) begin
                  state    <= ST_S1;
                  phase    <= 1'b0;
                  cur_ch   <= win_ch;
                  cur_type <= xfer_t'(win_mode[1:0]);
                  cur_str  <= win_mode[2];
               end else begin
                  state <= ST_SI;
                  phase <= 1'b0;
               end
            end
            default: state <= ST_SI;
         endcase
      end
   end

   assign hrq = (state != ST_SI) && (state != ST_SP);

   AST_PROG_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SI && cpu_sel) |=> (state == ST_SP)); // R3

   AST_NO_HOLD_NO_GO: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_S0 && !hlda) |=> (state != ST_S1)); // R4

   AST_WAIT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_S3 && !ready) |=> (state == ST_S3)); // R8

   AST_M2M_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_S4 && cur_type == XF_M2M && !phase) |=> (state == ST_S1 && phase)); // R7

endmodule

// File: rtl/dma_seq_cmd.sv
module dma_seq_cmd
   import dma_seq_pkg::*;
#(
   parameter int NCH  = 4,
   parameter int CH_W = 2
) (
   input  seq_state_t      state,
   input  logic            phase,
   input  logic [CH_W-1:0] cur_ch,
   input  xfer_t           cur_type,
   input  logic            ready,
   output logic            mem_rd,
   output logic            mem_wr,
   output logic            io_rd,
   output logic            io_wr,
   output logic            adr_inc,
   output logic            hold_load,
   output logic            dbus_oe,
   output logic [NCH-1:0]  dack
);

   logic cmd_on;
   logic in_xfer;
   logic is_m2m;

   assign cmd_on  = (state == ST_S2) || (state == ST_S3);
   assign in_xfer = cmd_on || (state == ST_S1) || (state == ST_S4);
   assign is_m2m  = (cur_type == XF_M2M);

   assign mem_rd    = cmd_on && ((cur_type == XF_M2IO) || (is_m2m && !phase));
   assign io_wr     = cmd_on && (cur_type == XF_M2IO);
   assign io_rd     = cmd_on && (cur_type == XF_IO2M);
   assign mem_wr    = cmd_on && ((cur_type == XF_IO2M) || (is_m2m && phase));
   assign adr_inc   = (state == ST_S4);
   assign hold_load = (state == ST_S3) && ready && is_m2m && !phase;
   assign dbus_oe   = in_xfer && is_m2m && phase;

   generate
      for (genvar gi = 0; gi < NCH; gi++) begin : g_ack
         assign dack[gi] = in_xfer && (cur_ch == CH_W'(gi));
      end
   endgenerate

endmodule

// File: rtl/dma_seq_hold.sv
module dma_seq_hold #(
   parameter int HOLD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [HOLD_W-1:0] d,
   output logic [HOLD_W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= d;
   end

   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(q)); // R6

endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
   import dma_seq_pkg::*;
#(
   parameter int NCH          = 4,
   parameter int HOLD_W       = 8,
   parameter int STRETCH_CLKS = 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NCH-1:0]        dreq,
   input  logic [MODE_W*NCH-1:0] chan_mode,
   input  logic                  cpu_sel,
   input  logic                  hlda,
   input  logic                  ready,
   input  logic [HOLD_W-1:0]     dbus_in,
   output logic                  hrq,
   output logic                  mem_rd,
   output logic                  mem_wr,
   output logic                  io_rd,
   output logic                  io_wr,
   output logic                  adr_inc,
   output logic [NCH-1:0]        dack,
   output logic [HOLD_W-1:0]     dbus_out,
   output logic                  dbus_oe
);

   localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;
   localparam int SCW  = (STRETCH_CLKS > 1) ? $clog2(STRETCH_CLKS + 1) : 1;

   generate
      if (NCH < 1 || NCH > 16) begin : g_bad_nch
         $error("dma_xfer_seq: NCH must be 1..16");
      end
      if (HOLD_W < 1) begin : g_bad_hold
         $error("dma_xfer_seq: HOLD_W must be at least 1");
      end
      if (STRETCH_CLKS < 1 || STRETCH_CLKS > 15) begin : g_bad_str
         $error("dma_xfer_seq: STRETCH_CLKS must be 1..15");
      end
   endgenerate

   logic              req_any;
   logic [CH_W-1:0]   win_ch;
   logic [MODE_W-1:0] win_mode;
   seq_state_t        state;
   logic              phase;
   logic [CH_W-1:0]   cur_ch;
   xfer_t             cur_type;
   logic              hold_load;

   dma_seq_arb #(.NCH(NCH), .CH_W(CH_W)) u_arb (
      .req      (dreq),
      .mode     (chan_mode),
      .any      (req_any),
      .win_ch   (win_ch),
      .win_mode (win_mode)
   );

   dma_seq_fsm #(.CH_W(CH_W), .STRETCH_CLKS(STRETCH_CLKS), .SCW(SCW)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .cpu_sel  (cpu_sel),
      .hlda     (hlda),
      .ready    (ready),
      .req_any  (req_any),
      .win_ch   (win_ch),
      .win_mode (win_mode),
      .state    (state),
      .phase    (phase),
      .cur_ch   (cur_ch),
      .cur_type (cur_type),
      .hrq      (hrq)
   );

   dma_seq_cmd #(.NCH(NCH), .CH_W(CH_W)) u_cmd (
      .state     (state),
      .phase     (phase),
      .cur_ch    (cur_ch),
      .cur_type  (cur_type),
      .ready     (ready),
      .mem_rd    (mem_rd),
      .mem_wr    (mem_wr),
      .io_rd     (io_rd),
      .io_wr     (io_wr),
      .adr_inc   (adr_inc),
      .hold_load (hold_load),
      .dbus_oe   (dbus_oe),
      .dack      (dack)
   );

   dma_seq_hold #(.HOLD_W(HOLD_W)) u_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (hold_load),
      .d     (dbus_in),
      .q     (dbus_out)
   );

   AST_STROBE_NEEDS_HRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd || mem_wr || io_rd || io_wr) |-> (hrq && dack != '0)); // R4

   AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dack)); // R5

   AST_NO_BUS_CONFLICT: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && io_rd) && !(mem_wr && io_wr)); // R6

   AST_INC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      adr_inc |=> !adr_inc); // R10

   AST_INC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      adr_inc |-> !(mem_rd || mem_wr || io_rd || io_wr)); // R10

endmodule

// File: tb/dma_xfer_seq_test.sv
module dma_xfer_seq_test;

   localparam int NCH = 4;
   localparam int HW  = 8;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NCH-1:0]  dreq = '0;
   logic [11:0]     chan_mode = '0;
   logic            cpu_sel = 1'b0;
   logic            hlda = 1'b1;
   logic            ready = 1'b1;
   logic [HW-1:0]   dbus_in = '0;
   logic            hrq, mem_rd, mem_wr, io_rd, io_wr, adr_inc, dbus_oe;
   logic [NCH-1:0]  dack;
   logic [HW-1:0]   dbus_out;
   wire  [3:0]      strb = {mem_rd, mem_wr, io_rd, io_wr};

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   dma_xfer_seq #(.NCH(NCH), .HOLD_W(HW), .STRETCH_CLKS(1)) uut (
      .clk(clk), .rst_n(rst_n), .dreq(dreq), .chan_mode(chan_mode),
      .cpu_sel(cpu_sel), .hlda(hlda), .ready(ready), .dbus_in(dbus_in),
      .hrq(hrq), .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr),
      .adr_inc(adr_inc), .dack(dack), .dbus_out(dbus_out), .dbus_oe(dbus_oe)
   );

   always #4 clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 20000) begin
         checks = checks + 1;
         fails  = fails + 1;
         $display("FAIL watchdog: run hung, act=%0d exp<=20000 cycles", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      checks = checks + 1;
      if (!ok) begin
         fails = fails + 1;
         $display("FAIL %s: act=%0h exp=%0h", req, act, expv);
      end
   endtask

   // dreq[32:29] modes[28:17] ack[16:13] first-strobe[12:9] len[8:5] inc[4:3] oe[2:0]
   // strobe nibble {mem_rd, mem_wr, io_rd, io_wr}; modes octal {ch3,ch2,ch1,ch0}
   localparam logic [32:0] VECS [0:7] = '{
      {4'b0001, 12'o0000, 4'b0001, 4'b1001, 4'd4,  2'd1, 3'd0},
      {4'b0001, 12'o0001, 4'b0001, 4'b0110, 4'd4,  2'd1, 3'd0},
      {4'b0001, 12'o0002, 4'b0001, 4'b1000, 4'd8,  2'd2, 3'd4},
      {4'b0001, 12'o0004, 4'b0001, 4'b1001, 4'd5,  2'd1, 3'd0},
      {4'b0110, 12'o0010, 4'b0010, 4'b0110, 4'd4,  2'd1, 3'd0},
      {4'b1000, 12'o6000, 4'b1000, 4'b1000, 4'd10, 2'd2, 3'd5},
      {4'b1011, 12'o0003, 4'b0010, 4'b1001, 4'd4,  2'd1, 3'd0},
      {4'b1100, 12'o0500, 4'b0100, 4'b0110, 4'd5,  2'd1, 3'd0}
   };

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk(hrq == 0 && dack == 0 && strb == 0 && !adr_inc && !dbus_oe, "R1 during reset",
          {hrq, dack, strb}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(hrq == 0 && dack == 0 && strb == 0 && !adr_inc && !dbus_oe, "R1 after reset",
          {hrq, dack, strb}, 0);

      // Vector table
      for (int i = 0; i < 8; i++) begin
         logic [32:0] v;
         int len, inc, oe;
         logic [3:0] first;
         bit dat_ok;
         v = VECS[i];
         dreq      = v[32:29];
         chan_mode = v[28:17];
         dbus_in   = 8'hA0 + 8'(i);
         @(negedge clk);
         chk(hrq == 1 && dack == 0, "R2 hold request latency", {hrq, dack}, 5'b10000);
         @(negedge clk);
         chk(dack == v[16:13], "R5 acknowledge channel", dack, v[16:13]);
         dreq = '0;
         len = 0; inc = 0; oe = 0; first = '0; dat_ok = 1'b1;
         while (dack != 0 && len < 40) begin
            if (first == 0) first = strb;
            if (adr_inc) inc++;
            if (dbus_oe) begin
               oe++;
               if (dbus_out !== dbus_in) dat_ok = 1'b0;
            end
            len++;
            @(negedge clk);
         end
         chk(len == int'(v[8:5]), "R6/R7/R9 cycle length", len, v[8:5]);
         chk(first == v[12:9], "R6/R7 command strobes", first, v[12:9]);
         chk(inc == int'(v[4:3]), "R10 increment pulses", inc, v[4:3]);
         chk(oe == int'(v[2:0]), "R7 data drive clocks", oe, v[2:0]);
         chk(dat_ok, "R7 holding register data", dbus_out, dbus_in);
         chk(hrq == 0, "R11 hold released", hrq, 0);
      end

      // R6: fly-by vectors after the last memory-to-memory one left A5 in place
      chk(dbus_out == 8'hA5, "R6 fly-by leaves holding register", dbus_out, 8'hA5);

      // R2: disabled channel ignored
      chan_mode = 12'o0003;
      dreq = 4'b0001;
      repeat (3) begin
         @(negedge clk);
         chk(hrq == 0 && dack == 0, "R2 disabled request ignored", hrq, 0);
      end
      dreq = '0;
      chan_mode = 12'o0000;
      @(negedge clk);

      // R3: program condition wins
      cpu_sel = 1'b1;
      dreq = 4'b0001;
      repeat (3) begin
         @(negedge clk);
         chk(hrq == 0, "R3 select blocks hold", hrq, 0);
      end
      cpu_sel = 1'b0;
      @(negedge clk);
      chk(hrq == 0, "R3 idle clock after select", hrq, 0);
      @(negedge clk);
      chk(hrq == 1, "R3 request served after select", hrq, 1);
      @(negedge clk);
      dreq = '0;
      while (dack != 0) @(negedge clk);

      // R4: wait for hold acknowledge
      hlda = 1'b0;
      dreq = 4'b0001;
      repeat (4) begin
         @(negedge clk);
         chk(hrq == 1 && dack == 0 && strb == 0, "R4 waiting for hlda", {hrq, dack, strb}, 9'h100);
      end
      hlda = 1'b1;
      @(negedge clk);
      chk(dack == 4'b0001, "R4 ack after hlda", dack, 1);
      dreq = '0;
      while (dack != 0) @(negedge clk);
      chk(hrq == 0, "R4 hold dropped", hrq, 0);

      // R8: ready wait states
      dreq = 4'b0001;
      repeat (2) @(negedge clk);
      dreq = '0;
      @(negedge clk);
      chk(strb == 4'b1001, "R8 strobes in S2", strb, 4'b1001);
      ready = 1'b0;
      repeat (3) begin
         @(negedge clk);
         chk(strb == 4'b1001 && !adr_inc, "R8 held in S3", {strb, adr_inc}, 5'b10010);
      end
      ready = 1'b1;
      @(negedge clk);
      chk(adr_inc && strb == 0, "R10 S4 after ready", {strb, adr_inc}, 1);
      @(negedge clk);
      chk(hrq == 0, "R11 idle after single transfer", hrq, 0);

      // R11: chained transfers keep the bus
      begin
         bit hrq_ok;
         int guard;
         hrq_ok = 1'b1;
         guard = 0;
         dreq = 4'b0110;
         repeat (2) @(negedge clk);
         chk(dack == 4'b0010, "R5 channel 1 before channel 2", dack, 4'b0010);
         dreq = 4'b0100;
         while (dack == 4'b0010 && guard < 20) begin
            if (!hrq) hrq_ok = 1'b0;
            guard++;
            @(negedge clk);
         end
         chk(dack == 4'b0100, "R11 next channel follows at once", dack, 4'b0100);
         chk(hrq_ok && hrq, "R11 hold kept between transfers", hrq, 1);
         dreq = '0;
         while (dack != 0) @(negedge clk);
         chk(hrq == 0, "R11 hold dropped at end", hrq, 0);
      end

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule